// File: doc/BRIEF.md
# Packed-Element Integer ALU Lane

This block is one integer execution lane of a vector unit. Every operation reads two 64-bit operand words. Those words are treated as packed elements of 8, 16, 32 or 64 bits, and each element is processed independently of its neighbours. A single adder built from eight byte slices does all of the addition, subtraction and comparison. The carry between two adjacent slices is either passed on or replaced. It is passed on inside an element and replaced at an element boundary, so no carry ever crosses into the next element.

The caller presents the operands, a 3-bit class field, a 6-bit operation field and an element-width select. It raises `in_valid` for one cycle per operation. The result comes out of a register one cycle later, together with `out_valid`. An encoding that the lane does not support produces no valid result and leaves the result register unchanged.

Top module: `simd_alu`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises with no operation issued, `out_valid` is 0 and `result` is all zeros.
- R2: An operation accepted at clock edge k shows its result on `result`, with `out_valid` high, after edge k. Any cycle with `in_valid` low yields `out_valid` low at the next edge.
- R3: With `class_sel`=000 and `op_sel`=000000, each element of `result` is the sum of the matching elements of `op_a` and `op_b` modulo 2^w. `elem_w` selects w: 0→8, 1→16, 2→32, 3→64 bits, and element e occupies bits [e*w +: w].
- R4: With `op_sel`=000010, each element is a−b modulo 2^w, and no borrow passes between elements.
- R5: With `op_sel`=001001, 001010 and 001011, `result` is the bitwise AND, OR and XOR of the operands respectively.
- R6: With `op_sel`=100101 (left logical), 101000 (right logical) and 101001 (right arithmetic), each element of `op_a` is shifted by the matching element of `op_b` taken modulo w. The arithmetic right shift fills vacated bits with the element's sign bit.
- R7: With `op_sel`=011000 (equal), 011001 (not equal), 011010 (unsigned less-than) and 011011 (signed less-than), each element becomes all ones when its comparison is true and all zeros when it is false.
- R8: With `op_sel`=000100, 000101, 000110 and 000111, each element becomes the unsigned minimum, signed minimum, unsigned maximum and signed maximum of the operand elements respectively.
- R9: If `class_sel` is not 000, or `op_sel` is not one of the codes listed in R3–R8, the lane gives `out_valid` low at the next edge and `result` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Issue an operation this cycle |
| op_a | input | 64 | First operand word |
| op_b | input | 64 | Second operand word, also carries the shift amounts |
| class_sel | input | 3 | Operation class; only 000 is accepted |
| op_sel | input | 6 | Operation code |
| elem_w | input | 2 | Element width select |
| out_valid | output | 1 | Result register holds a fresh result |
| result | output | 64 | Registered result word |

## Verification
On every cycle the assertions check four things: the one-cycle latency, that the result is held when no legal operation was issued, that every compare result consists of whole all-ones or all-zeros elements, and that every min/max element equals one of its two source elements. They also check sums and differences against an element-wise arithmetic function, so a carry that leaks across a boundary shows up at once. Some behaviour only the bench's sweeps can show. One case is a compare that returns the wrong polarity, since that still gives a well-formed mask. Others are shift counts wrapping modulo the element width, sign fill on arithmetic shifts, and the choice between signed and unsigned ordering on boundary values such as 0x80 and 0x7F.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;

  localparam int WORD_W = 64;
  localparam int NBYTES = WORD_W / 8;
  localparam int EW_BITS = 2;

  typedef enum logic [4:0] {
    OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR,
    OP_SLL, OP_SRL, OP_SRA,
    OP_SEQ, OP_SNE, OP_SLTU, OP_SLT,
    OP_MINU, OP_MIN, OP_MAXU, OP_MAX,
    OP_BAD
  } op_e;

  function automatic op_e decode_op(input logic [2:0] cls, input logic [5:0] code);
    op_e r;
    if (cls != 3'b000) return OP_BAD;
    case (code)
      6'b000000: r = OP_ADD;
      6'b000010: r = OP_SUB;
      6'b000100: r = OP_MINU;
      6'b000101: r = OP_MIN;
      6'b000110: r = OP_MAXU;
      6'b000111: r = OP_MAX;
      6'b001001: r = OP_AND;
      6'b001010: r = OP_OR;
      6'b001011: r = OP_XOR;
      6'b011000: r = OP_SEQ;
      6'b011001: r = OP_SNE;
      6'b011010: r = OP_SLTU;
      6'b011011: r = OP_SLT;
      6'b100101: r = OP_SLL;
      6'b101000: r = OP_SRL;
      6'b101001: r = OP_SRA;
      default:   r = OP_BAD;
    endcase
    return r;
  endfunction

  // True when byte slice i is the lowest byte of its element.
  function automatic logic elem_start(input int i, input logic [EW_BITS-1:0] ew);
    int span;
    span = 1 << int'(ew);
    return (i % span) == 0;
  endfunction

  // Widen one flag per byte into a full byte of ones or zeros.
  function automatic logic [WORD_W-1:0] spread(input logic [NBYTES-1:0] f);
    logic [WORD_W-1:0] r;
    for (int i = 0; i < NBYTES; i++) r[i*8 +: 8] = {8{f[i]}};
    return r;
  endfunction

  function automatic logic [WORD_W-1:0] elem_mask(input logic [EW_BITS-1:0] ew);
    int w;
    w = 8 << int'(ew);
    return (w >= WORD_W) ? '1 : ((64'd1 << w) - 64'd1);
  endfunction

  // Element-wise addition, written as whole-element arithmetic.
  function automatic logic [WORD_W-1:0] lane_add(input logic [WORD_W-1:0] a,
                                                 input logic [WORD_W-1:0] b,
                                                 input logic [EW_BITS-1:0] ew);
    logic [WORD_W-1:0] r, m;
    int w;
    w = 8 << int'(ew);
    m = elem_mask(ew);
    r = '0;
    for (int e = 0; e < NBYTES; e++)
      if (e * w < WORD_W) r |= ((((a >> (e*w)) & m) + ((b >> (e*w)) & m)) & m) << (e*w);
    return r;
  endfunction

  // kind: 0 left logical, 1 right logical, 2 right arithmetic
  function automatic logic [WORD_W-1:0] lane_shift(input logic [WORD_W-1:0] a,
                                                   input logic [WORD_W-1:0] b,
                                                   input logic [EW_BITS-1:0] ew,
                                                   input logic [1:0] kind);
    logic [WORD_W-1:0] r, bs;
    int w, base, amt, src;
    w = 8 << int'(ew);
    for (int i = 0; i < WORD_W; i++) begin
      base = i - (i % w);
      bs = b >> base;
      amt = int'(bs[5:0]) % w;
      if (kind == 2'd0) begin
        src = i - amt;
        r[i] = (src >= base) ? a[src] : 1'b0;
      end else begin
        src = i + amt;
        if (src < base + w) r[i] = a[src];
        else r[i] = (kind == 2'd2) ? a[base + w - 1] : 1'b0;
      end
    end
    return r;
  endfunction

  // Every element is entirely ones or entirely zeros.
  function automatic logic is_elem_mask(input logic [WORD_W-1:0] v, input logic [EW_BITS-1:0] ew);
    logic [WORD_W-1:0] m, x;
    int w;
    logic ok;
    w = 8 << int'(ew);
    m = elem_mask(ew);
    ok = 1'b1;
    for (int e = 0; e < NBYTES; e++)
      if (e * w < WORD_W) begin
        x = (v >> (e*w)) & m;
        if (x != '0 && x != m) ok = 1'b0;
      end
    return ok;
  endfunction

  // Every element of v equals the matching element of a or of b.
  function automatic logic picks_operand(input logic [WORD_W-1:0] v, input logic [WORD_W-1:0] a,
                                         input logic [WORD_W-1:0] b, input logic [EW_BITS-1:0] ew);
    logic [WORD_W-1:0] m, x;
    int w;
    logic ok;
    w = 8 << int'(ew);
    m = elem_mask(ew);
    ok = 1'b1;
    for (int e = 0; e < NBYTES; e++)
      if (e * w < WORD_W) begin
        x = (v >> (e*w)) & m;
        if (x != ((a >> (e*w)) & m) && x != ((b >> (e*w)) & m)) ok = 1'b0;
      end
    return ok;
  endfunction

endpackage

// File: rtl/simd_byte_adder.sv
module simd_byte_adder
  import simd_alu_pkg::*;
#(
  parameter int NB = NBYTES,
  localparam int W = NB * 8
) (
  input  logic [W-1:0]         a,
  input  logic [W-1:0]         b,
  input  logic                 sub,
  input  logic [EW_BITS-1:0]   ew,
  output logic [W-1:0]         sum,
  output logic [NB-1:0]        cout
);
  for (genvar i = 0; i < NB; i++) begin : g_slice
    logic [7:0] bx;
    logic       cin;
    assign bx = sub ? ~b[i*8 +: 8] : b[i*8 +: 8];
    if (i == 0) begin : g_low
      assign cin = sub;
    end else begin : g_link
      // pass the carry inside an element, inject sub at an element start
      assign cin = elem_start(i, ew) ? sub : cout[i-1];
    end
    assign {cout[i], sum[i*8 +: 8]} = {1'b0, a[i*8 +: 8]} + {1'b0, bx} + {8'd0, cin};
  end
endmodule

// File: rtl/simd_cmp.sv
module simd_cmp
  import simd_alu_pkg::*;
#(
  parameter int NB = NBYTES,
  localparam int W = NB * 8
) (
  input  logic [W-1:0]       a,
  input  logic [W-1:0]       b,
  input  logic [W-1:0]       diff,
  input  logic [NB-1:0]      cout,
  input  logic [EW_BITS-1:0] ew,
  output logic [NB-1:0]      eq_f,
  output logic [NB-1:0]      ltu_f,
  output logic [NB-1:0]      lts_f
);
  logic [NB-1:0] byte_zero;

  always_comb begin
    for (int j = 0; j < NB; j++) byte_zero[j] = (diff[j*8 +: 8] == 8'd0);
    for (int i = 0; i < NB; i++) begin
      int span, top;
      logic sa, sb;
      span = 1 << int'(ew);
      top = i - (i % span) + span - 1;
      // no carry out of a+~b+1 means a borrow: a < b unsigned
      ltu_f[i] = ~cout[top];
      sa = a[top*8 + 7];
      sb = b[top*8 + 7];
      lts_f[i] = (sa != sb) ? sa : diff[top*8 + 7];
      eq_f[i] = 1'b1;
      for (int j = 0; j < NB; j++)
        if ((j / span) == (i / span)) eq_f[i] = eq_f[i] & byte_zero[j];
    end
  end
endmodule

// File: rtl/simd_shifter.sv
module simd_shifter
  import simd_alu_pkg::*;
(
  input  logic [WORD_W-1:0]  a,
  input  logic [WORD_W-1:0]  b,
  input  logic [EW_BITS-1:0] ew,
  input  logic [1:0]         kind,
  output logic [WORD_W-1:0]  y
);
  always_comb y = lane_shift(a, b, ew, kind);
endmodule

// File: rtl/simd_alu.sv
module simd_alu
  import simd_alu_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [WORD_W-1:0]  op_a,
  input  logic [WORD_W-1:0]  op_b,
  input  logic [2:0]         class_sel,
  input  logic [5:0]         op_sel,
  input  logic [EW_BITS-1:0] elem_w,
  output logic               out_valid,
  output logic [WORD_W-1:0]  result
);
  op_e               op;
  logic              legal, fire, use_sub;
  logic [WORD_W-1:0] sum, sh_y, res_d, lt_sel;
  logic [NBYTES-1:0] cout, eq_f, ltu_f, lts_f;
  logic [1:0]        sh_kind;
  logic              is_cmp, is_minmax;

  assign op        = decode_op(class_sel, op_sel);
  assign legal     = (op != OP_BAD);
  assign fire      = in_valid & legal;
  assign is_cmp    = (op == OP_SEQ) || (op == OP_SNE) || (op == OP_SLTU) || (op == OP_SLT);
  assign is_minmax = (op == OP_MINU) || (op == OP_MIN) || (op == OP_MAXU) || (op == OP_MAX);
  assign use_sub   = (op == OP_SUB) || is_cmp || is_minmax;
  assign sh_kind   = (op == OP_SLL) ? 2'd0 : (op == OP_SRL) ? 2'd1 : 2'd2;

  simd_byte_adder #(.NB(NBYTES)) u_add (
    .a(op_a), .b(op_b), .sub(use_sub), .ew(elem_w), .sum(sum), .cout(cout)
  );

  simd_cmp #(.NB(NBYTES)) u_cmp (
    .a(op_a), .b(op_b), .diff(sum), .cout(cout), .ew(elem_w),
    .eq_f(eq_f), .ltu_f(ltu_f), .lts_f(lts_f)
  );

  simd_shifter u_shift (
    .a(op_a), .b(op_b), .ew(elem_w), .kind(sh_kind), .y(sh_y)
  );

  assign lt_sel = (op == OP_MIN || op == OP_MAX) ? spread(lts_f) : spread(ltu_f);

  always_comb begin
    case (op)
      OP_ADD, OP_SUB:  res_d = sum;
      OP_AND:          res_d = op_a & op_b;
      OP_OR:           res_d = op_a | op_b;
      OP_XOR:          res_d = op_a ^ op_b;
      OP_SLL, OP_SRL,
      OP_SRA:          res_d = sh_y;
      OP_SEQ:          res_d = spread(eq_f);
      OP_SNE:          res_d = spread(~eq_f);
      OP_SLTU:         res_d = spread(ltu_f);
      OP_SLT:          res_d = spread(lts_f);
      OP_MINU, OP_MIN: res_d = (op_a & lt_sel) | (op_b & ~lt_sel);
      OP_MAXU, OP_MAX: res_d = (op_b & lt_sel) | (op_a & ~lt_sel);
      default:         res_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= fire;
      if (fire) result <= res_d;
    end
  end

  // R2: a valid result always traces back to an issue one cycle earlier
  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));

  // R9: nothing legal issued, nothing written
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(fire) |-> $stable(result));

  // R3: byte-slice adder agrees with whole-element arithmetic
  assert_add_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(op) == OP_ADD) |->
      result == lane_add($past(op_a), $past(op_b), $past(elem_w)));

  // R4: difference plus subtrahend gives back the minuend, element by element
  assert_sub_inverse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(op) == OP_SUB) |->
      lane_add(result, $past(op_b), $past(elem_w)) == $past(op_a));

  // R7: compare results are whole-element masks
  assert_cmp_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(is_cmp)) |-> is_elem_mask(result, $past(elem_w)));

  // R8: min/max never invents a value
  assert_minmax_pick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(is_minmax)) |->
      picks_operand(result, $past(op_a), $past(op_b), $past(elem_w)));

endmodule

// File: tb/tb_simd_alu.sv
`timescale 1ns/1ps
module tb_simd_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] op_a = '0, op_b = '0;
  logic [2:0]  class_sel = '0;
  logic [5:0]  op_sel = '0;
  logic [1:0]  elem_w = '0;
  logic        out_valid;
  logic [63:0] result;

  int total = 0, bad = 0;
  logic [63:0] last_res = '0;
  logic [63:0] seed = 64'h9E3779B97F4A7C15;

  always #2.5 clk = ~clk;

  simd_alu dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .class_sel(class_sel), .op_sel(op_sel), .elem_w(elem_w),
    .out_valid(out_valid), .result(result)
  );

  function automatic string req_of(input logic [5:0] c);
    case (c)
      6'b000000: return "R3";
      6'b000010: return "R4";
      6'b001001, 6'b001010, 6'b001011: return "R5";
      6'b100101, 6'b101000, 6'b101001: return "R6";
      6'b011000, 6'b011001, 6'b011010, 6'b011011: return "R7";
      6'b000100, 6'b000101, 6'b000110, 6'b000111: return "R8";
      default: return "R9";
    endcase
  endfunction

  // Reference model built per element from the requirement text.
  function automatic logic [63:0] model(input logic [5:0] c, input logic [63:0] a,
                                        input logic [63:0] b, input int ew);
    int w, n, amt;
    longint unsigned m, xa, xb, y;
    longint sa, sb;
    logic [63:0] r;
    w = 8 << ew;
    n = 64 / w;
    m = (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 1);
    r = '0;
    for (int e = 0; e < n; e++) begin
      xa = (a >> (e*w)) & m;
      xb = (b >> (e*w)) & m;
      sa = $signed(xa << (64 - w)) >>> (64 - w);
      sb = $signed(xb << (64 - w)) >>> (64 - w);
      amt = int'(xb % longint'(w));
      case (c)
        6'b000000: y = xa + xb;
        6'b000010: y = xa - xb;
        6'b001001: y = xa & xb;
        6'b001010: y = xa | xb;
        6'b001011: y = xa ^ xb;
        6'b100101: y = xa << amt;
        6'b101000: y = xa >> amt;
        6'b101001: y = longint'(sa >>> amt);
        6'b011000: y = (xa == xb) ? m : 0;
        6'b011001: y = (xa != xb) ? m : 0;
        6'b011010: y = (xa < xb) ? m : 0;
        6'b011011: y = (sa < sb) ? m : 0;
        6'b000100: y = (xa < xb) ? xa : xb;
        6'b000101: y = (sa < sb) ? xa : xb;
        6'b000110: y = (xa < xb) ? xb : xa;
        default:   y = (sa < sb) ? xb : xa;
      endcase
      r |= (y & m) << (e*w);
    end
    return r;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: got=%h expected=%h", req, what, got, exp);
    end
  endtask

  // Drive at a falling edge, sample at the next falling edge.
  task automatic run(input logic [2:0] cls, input logic [5:0] c, input int ew,
                     input logic [63:0] a, input logic [63:0] b, input logic legal);
    logic [63:0] exp;
    in_valid = 1'b1; class_sel = cls; op_sel = c; elem_w = 2'(ew); op_a = a; op_b = b;
    @(negedge clk);
    in_valid = 1'b0;
    exp = legal ? model(c, a, b, ew) : last_res;
    check(legal ? req_of(c) : "R9", "result", result, exp);
    check(legal ? "R2" : "R9", "valid", {63'd0, out_valid}, {63'd0, legal});
    last_res = exp;
  endtask

  function automatic logic [63:0] next_rand(input logic [63:0] s);
    logic [63:0] x;
    x = s ^ (s << 13);
    x = x ^ (x >> 7);
    return x ^ (x << 17);
  endfunction

  localparam logic [5:0] CODES [16] = '{6'b000000, 6'b000010, 6'b001001, 6'b001010,
    6'b001011, 6'b100101, 6'b101000, 6'b101001, 6'b011000, 6'b011001, 6'b011010,
    6'b011011, 6'b000100, 6'b000101, 6'b000110, 6'b000111};
  localparam logic [63:0] EDGES [6] = '{64'h0, 64'hFFFF_FFFF_FFFF_FFFF,
    64'h8080_8080_8080_8080, 64'h7F7F_7F7F_7F7F_7F7F, 64'h8000_0000_0000_0000,
    64'h0123_4567_89AB_CDEF};

  initial begin
    #(5.0 * 150000);
    bad++; total++;
    $display("FAIL watchdog: got=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", "valid in reset", {63'd0, out_valid}, 64'd0);
    check("R1", "result in reset", result, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "valid after reset", {63'd0, out_valid}, 64'd0);
    check("R1", "result after reset", result, 64'd0);

    // Edge-value cross product for every op and width
    for (int ew = 0; ew < 4; ew++)
      for (int k = 0; k < 16; k++)
        for (int i = 0; i < 6; i++)
          for (int j = 0; j < 6; j++)
            run(3'b000, CODES[k], ew, EDGES[i], EDGES[j], 1'b1);

    // Pseudo-random sweep
    for (int ew = 0; ew < 4; ew++)
      for (int k = 0; k < 16; k++)
        for (int t = 0; t < 16; t++) begin
          logic [63:0] ra, rb;
          seed = next_rand(seed); ra = seed;
          seed = next_rand(seed); rb = seed;
          if (t[0]) rb = ra ^ (rb & 64'h0000_FFFF_0000_00FF); // partly equal elements
          run(3'b000, CODES[k], ew, ra, rb, 1'b1);
        end

    // Exhaustive 8-bit add and subtract over every byte value (R3, R4)
    for (int v = 0; v < 256; v++) begin
      logic [63:0] pa, pb;
      for (int e = 0; e < 8; e++) begin
        pa[e*8 +: 8] = 8'(v + e * 31);
        pb[e*8 +: 8] = 8'(v * 7 + e * 97 + 3);
      end
      run(3'b000, 6'b000000, 0, pa, pb, 1'b1);
      run(3'b000, 6'b000010, 0, pa, pb, 1'b1);
    end

    // R3: carry must stop at each boundary; R4: borrow likewise
    run(3'b000, 6'b000000, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0001_0001_0001_0001, 1'b1);
    run(3'b000, 6'b000010, 2, 64'h0000_0000_0000_0000, 64'h0000_0001_0000_0001, 1'b1);

    // R6: shift count wraps modulo the element width
    run(3'b000, 6'b100101, 0, 64'h0101_0101_0101_0101, 64'h0908_0F07_1011_0001, 1'b1);
    run(3'b000, 6'b101001, 1, 64'h8000_8000_4000_8000, 64'h0011_000F_0021_0040, 1'b1);

    // R9: illegal class, then illegal code; result holds
    run(3'b001, 6'b000000, 0, 64'h1111, 64'h2222, 1'b0);
    run(3'b000, 6'b111111, 3, 64'h3333, 64'h4444, 1'b0);
    run(3'b000, 6'b000011, 2, 64'h5555, 64'h6666, 1'b0);

    // R2: idle cycle gives no valid and keeps the result
    @(negedge clk);
    check("R2", "idle valid", {63'd0, out_valid}, 64'd0);
    check("R9", "idle hold", result, last_res);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule